// File: doc/BRIEF.md
# One-Wire Bus Reset and Presence Controller

This block is the reset part of a one-wire bus master. A host sends it byte commands. Each command comes with a valid strobe. The block answers in the same cycle with an accept flag. Two command codes are known.

The bus-reset command runs one timed bus cycle. The block pulls the open-drain line low for a parameterised number of clock cycles and then releases it. After release it samples the line twice, at two points, each one cycle count past the release:
- The earlier sample decides the short flag.
- The later sample decides the presence flag.

The master-reset command can be given at any time, even in the middle of a bus cycle. It aborts the cycle and clears the status. It also raises a device-reset flag, which stays set until the next bus-reset command is accepted.

All times are counted in system clock cycles. The bus output is a pull-low enable: a pad cell turns it into an open-drain driver. The line input must already be synchronised to the clock.

Top module: `owbus_reset_ctl`

## Requirements
The acceptance edge is the rising clock edge at which `cmd_valid` and `cmd_accept` are both high. "Cycle k" is the clock period that begins k edges after the acceptance edge. Cycle 0 follows the acceptance edge directly.

- R1: While `rst_n` is low, and after it rises, the block shows `busy`=0, `bus_pull_low`=0, `presence`=0, `short_det`=0 and `dev_reset`=1.
- R2: When `busy` is 0, the bus-reset code 8'hB4 on `cmd_code` with `cmd_valid` raises `cmd_accept` in the same cycle. `busy` is then 1 for cycles 0 to 2·RSTL_CYC−1 and 0 from cycle 2·RSTL_CYC.
- R3: After a bus-reset command is accepted, `bus_pull_low` is 1 for cycles 0 to RSTL_CYC−1 and 0 from cycle RSTL_CYC.
- R4: `short_det` takes the value NOT `line_in`, as sampled at the edge that ends cycle RSTL_CYC+SI_CYC. The new value shows from cycle RSTL_CYC+SI_CYC+1.
- R5: `presence` takes the value NOT `line_in`, as sampled at the edge that ends cycle RSTL_CYC+MSP_CYC. The new value shows from cycle RSTL_CYC+MSP_CYC+1.
- R6: An accepted bus-reset command clears `presence` and `short_det` at once, so both are 0 in cycle 0. After they are sampled, both flags hold their values until the next accepted command.
- R7: When `busy` is 1, a bus-reset command is not accepted (`cmd_accept`=0). It has no effect: the running cycle ends at its original time.
- R8: The master-reset code 8'hF0 is accepted whatever the state of `busy`. In the next cycle it gives `busy`=0, `bus_pull_low`=0, `presence`=0, `short_det`=0 and `dev_reset`=1.
- R9: An accepted bus-reset command clears `dev_reset` to 0.
- R10: Any code other than 8'hF0 and 8'hB4 is never accepted and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_code | input | 8 | Command byte |
| cmd_accept | output | 1 | Command taken this cycle |
| line_in | input | 1 | Synchronised level of the bus line |
| bus_pull_low | output | 1 | 1 = drive the line low, 0 = release it |
| busy | output | 1 | Bus cycle in progress |
| presence | output | 1 | Presence pulse seen in the last bus cycle |
| short_det | output | 1 | Line held low after release in the last bus cycle |
| dev_reset | output | 1 | Master reset seen since the last bus-reset command |

## Verification
`cmd_accept` is combinational, so it is checked in the same cycle as the command. Every other result is due one edge after the event that causes it:
- the line drive and `busy` change in cycle 0;
- the line drive drops in cycle RSTL_CYC and `busy` drops in cycle 2·RSTL_CYC;
- each flag shows the cycle after its sample edge.

The bench counts cycles from the acceptance edge. It drives `line_in` at each falling edge from a model of the bus: the master's low pulse, a slave pulse with a sweep of start and length values, and an optional short. Once per cycle it compares every output with the value the requirements give for that cycle count.

// File: rtl/owbus_reset_ctl.sv
module owbus_reset_ctl #(
  parameter int RSTL_CYC = 4800,
  parameter int MSP_CYC  = 700,
  parameter int SI_CYC   = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       cmd_accept,
  input  logic       line_in,
  output logic       bus_pull_low,
  output logic       busy,
  output logic       presence,
  output logic       short_det,
  output logic       dev_reset
);
  localparam logic [7:0] CODE_MRST = 8'hF0;
  localparam logic [7:0] CODE_BRST = 8'hB4;
  localparam int CW = $clog2(2 * RSTL_CYC + 1);
  localparam logic [CW-1:0] END_LOW = CW'(RSTL_CYC);
  localparam logic [CW-1:0] AT_SD   = CW'(RSTL_CYC + SI_CYC);
  localparam logic [CW-1:0] AT_PD   = CW'(RSTL_CYC + MSP_CYC);
  localparam logic [CW-1:0] AT_LAST = CW'(2 * RSTL_CYC - 1);

  logic [CW-1:0] cnt;
  logic go_mrst, go_brst;

  assign go_mrst      = cmd_valid && cmd_code == CODE_MRST;
  assign go_brst      = cmd_valid && cmd_code == CODE_BRST && !busy;
  assign cmd_accept   = go_mrst || go_brst;
  assign bus_pull_low = busy && cnt < END_LOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      presence  <= 1'b0;
      short_det <= 1'b0;
      dev_reset <= 1'b1;
    end else if (go_mrst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      presence  <= 1'b0;
      short_det <= 1'b0;
      dev_reset <= 1'b1;
    end else if (go_brst) begin
      busy      <= 1'b1;
      cnt       <= '0;
      presence  <= 1'b0;
      short_det <= 1'b0;
      dev_reset <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == AT_SD)   short_det <= ~line_in;
      if (cnt == AT_PD)   presence  <= ~line_in;
      if (cnt == AT_LAST) busy      <= 1'b0;
    end
  end
endmodule

module owbus_reset_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       cmd_accept,
  input logic       bus_pull_low,
  input logic       busy,
  input logic       presence,
  input logic       short_det,
  input logic       dev_reset
);
  a_r7_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_code == 8'hB4) |-> !cmd_accept);
  a_r3_pull_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull_low |-> busy);
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_code == 8'hB4) |=> (busy && bus_pull_low && !dev_reset));
  a_r8_mrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_code == 8'hF0) |=> (!busy && dev_reset && !presence && !short_det));
  a_r6_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_accept) |=> ($stable(presence) && $stable(short_det)));
  a_r10_unknown_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != 8'hB4 && cmd_code != 8'hF0) |-> !cmd_accept);
endmodule

bind owbus_reset_ctl owbus_reset_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_accept(cmd_accept), .bus_pull_low(bus_pull_low), .busy(busy),
  .presence(presence), .short_det(short_det), .dev_reset(dev_reset)
);

// File: tb/owbus_reset_ctl_bench.sv
module owbus_reset_ctl_bench;
  localparam int PER = 10;
  localparam int R = 12, M = 5, S = 2;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, line_in = 1'b1;
  logic [7:0] cmd_code = 8'h00;
  logic cmd_accept, bus_pull_low, busy, presence, short_det, dev_reset;
  int vecs = 0, errs = 0;

  always #(PER/2) clk = ~clk;

  owbus_reset_ctl #(.RSTL_CYC(R), .MSP_CYC(M), .SI_CYC(S)) u_owbus_reset_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_accept(cmd_accept), .line_in(line_in), .bus_pull_low(bus_pull_low),
    .busy(busy), .presence(presence), .short_det(short_det), .dev_reset(dev_reset));

  task automatic chk(string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic state(string req, logic b, logic p, logic pd, logic sd, logic dr);
    chk({req, " busy"}, busy, b);
    chk({req, " pull"}, bus_pull_low, p);
    chk({req, " presence"}, presence, pd);
    chk({req, " short"}, short_det, sd);
    chk({req, " dev_reset"}, dev_reset, dr);
  endtask

  // issue a command at the current negedge, check accept, step to next negedge
  task automatic issue(logic [7:0] code, logic exp_acc, string req);
    cmd_valid = 1'b1; cmd_code = code;
    #1 chk({req, " accept"}, cmd_accept, exp_acc);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 8'h00;
  endtask

  function automatic logic low_at(int n, int ps, int pl, bit sh);
    return (n < R) || sh || (n >= ps && n < ps + pl);
  endfunction

  task automatic run(int ps, int pl, bit sh);
    logic es, ep;
    es = low_at(R + S, ps, pl, sh);
    ep = low_at(R + M, ps, pl, sh);
    issue(8'hB4, 1'b1, "R2");
    for (int n = 0; n <= 2 * R + 1; n++) begin
      line_in = ~low_at(n, ps, pl, sh);
      #1;
      chk("R2 busy window", busy, n < 2 * R);
      chk("R3 pull window", bus_pull_low, n < R);
      chk("R4/R6 short", short_det, (n > R + S) ? es : 1'b0);
      chk("R5/R6 presence", presence, (n > R + M) ? ep : 1'b0);
      chk("R9 dev_reset", dev_reset, 1'b0);
      @(negedge clk);
    end
    line_in = 1'b1;
  endtask

  initial begin
    #(PER * 150000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    state("R1 in reset", 0, 0, 0, 0, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    state("R1 after reset", 0, 0, 0, 0, 1);
    @(negedge clk);

    // R10: unknown code idle
    issue(8'h3C, 1'b0, "R10");
    #1 state("R10 no effect", 0, 0, 0, 0, 1);
    @(negedge clk);

    // sweep of slave pulse start/length and short
    for (int sh = 0; sh < 2; sh++)
      for (int ps = R; ps <= R + M + 2; ps++)
        for (int pl = 1; pl <= 3; pl++)
          run(ps, pl, sh[0]);

    // R6/R8/R10: flags set, then unknown code, then F0 idle clears
    run(R, 2 * R, 1'b0);
    issue(8'hA5, 1'b0, "R10 after run");
    #1 state("R10 flags kept", 0, 0, 1, 1, 0);
    @(negedge clk);
    issue(8'hF0, 1'b1, "R8 idle");
    #1 state("R8 idle clear", 0, 0, 0, 0, 1);
    @(negedge clk);

    // R7: second B4 while busy ignored, cycle ends on time
    issue(8'hB4, 1'b1, "R7 start");
    for (int n = 0; n <= 2 * R; n++) begin
      if (n == 3) begin
        cmd_valid = 1'b1; cmd_code = 8'hB4;
        #1 chk("R7 reject accept", cmd_accept, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h00;
        continue;
      end
      #1;
      chk("R7 busy unchanged", busy, n < 2 * R);
      chk("R7 pull unchanged", bus_pull_low, n < R);
      @(negedge clk);
    end

    // R8: F0 aborts mid-cycle
    issue(8'hB4, 1'b1, "R8 start");
    repeat (4) @(negedge clk);
    #1 chk("R8 pulling before abort", bus_pull_low, 1'b1);
    issue(8'hF0, 1'b1, "R8 abort");
    #1 state("R8 abort", 0, 0, 0, 0, 1);
    repeat (2 * R) @(negedge clk);
    #1 state("R8 stays idle", 0, 0, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule